// File: doc/BRIEF.md
# Operand Mode Decoder

This block turns the 6-bit operand field of a 16-bit instruction into the place the operand lives. That place is one of four kinds: a general register, a memory word, one of the three special registers (stack pointer, program counter, overflow), or a literal value. The block only works out the location. It does not read memory and it does not store registers.

The block takes the following inputs:
- the operand code;
- the eight general register values;
- the stack pointer;
- the program counter;
- the word that follows the instruction, already fetched by the fetch unit.

It returns the following:
- the location kind;
- a selector, which is a register index, a memory address or a special-register number;
- a literal value;
- a flag that marks the following word as consumed;
- the program counter after that word;
- the stack pointer after a push or a pop.

Stack push, stack pop, stack peek, indexed addressing through the following word, and short literals held in the code itself all come out of one decode. A fetch unit can therefore advance its program counter and stack pointer directly from the result. A request is registered on the clock edge where `in_valid` is high. Its result appears on the outputs in the next cycle, together with `out_valid`.

Top module: `operand_mode_decoder`

## Requirements
- R1: For codes 0x00 to 0x07 the kind is register (encoding 0), the selector is the register number (code & 7) and no word is consumed.
- R2: For codes 0x08 to 0x0F the kind is memory (encoding 1) and the address is the value of register (code & 7).
- R3: For codes 0x10 to 0x17 the kind is memory and the address is (register (code & 7) + following word) modulo 65536.
- R4: Code 0x18 pops the stack. The address is the incoming stack pointer and the new stack pointer is that value plus one, modulo 65536.
- R5: Code 0x19 peeks at the stack, with address equal to the stack pointer. Every code other than 0x18 and 0x1A returns the incoming stack pointer unchanged as the new stack pointer.
- R6: Code 0x1A pushes onto the stack. The stack pointer is first reduced by one modulo 65536, and both the address and the new stack pointer equal that reduced value.
- R7: Codes 0x1B, 0x1C and 0x1D give kind special (encoding 2), with selector 0 for the stack pointer, 1 for the program counter and 2 for the overflow register.
- R8: For code 0x1E the kind is memory and the address is the following word.
- R9: For code 0x1F the kind is literal (encoding 3) and the literal value is the following word.
- R10: For codes 0x20 to 0x3F the kind is literal, the literal value is (code & 0x1F) and no word is consumed.
- R11: The consumed-word flag is high for exactly codes 0x10 to 0x17, 0x1E and 0x1F. The output program counter is the input program counter plus that flag, modulo 65536.
- R12: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. Reset clears `out_valid` and every result output to zero.
- R13: The selector is zero for literal kinds, and the literal value is zero for every kind other than literal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand request this cycle |
| opnd_code | input | 6 | Operand field of the instruction |
| gpr_values | input | 128 | Eight general registers, register 0 in bits 15:0 |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Program counter, pointing at the following word |
| next_word | input | 16 | Word at the program counter |
| out_valid | output | 1 | Result valid |
| loc_kind | output | 2 | 0 register, 1 memory, 2 special, 3 literal |
| loc_sel | output | 16 | Register index, memory address or special number |
| lit_value | output | 16 | Literal value |
| word_used | output | 1 | Following word consumed |
| pc_next | output | 16 | Program counter after the operand |
| sp_next | output | 16 | Stack pointer after the operand |

## Verification
The assertions assume that `next_word`, `sp_in` and `gpr_values` describe the request in the same cycle that `in_valid` is high. They also assume that the code is never X while `in_valid` is high. The bench holds every input stable from one falling edge to the next and drives all 64 codes with defined values. It also exercises the wrap cases at the boundaries: a stack pointer of 0 on a push, 0xFFFF on a pop, a program counter of 0xFFFF, and an indexed sum that overflows 16 bits.

// File: rtl/opd_pkg.sv
package opd_pkg;
    parameter int WORD_W   = 16;
    parameter int NUM_REGS = 8;
    parameter int CODE_W   = 6;
    localparam int IDX_W   = $clog2(NUM_REGS);
    localparam int LIT_W   = CODE_W - 1;

    typedef enum logic [1:0] {
        LOC_GPR  = 2'd0,
        LOC_MEM  = 2'd1,
        LOC_SPEC = 2'd2,
        LOC_LIT  = 2'd3
    } loc_kind_e;

    typedef enum logic [3:0] {
        M_REG, M_IND, M_IDX, M_POP, M_PEEK, M_PUSH,
        M_SPR, M_ABS, M_NEXTLIT, M_SHORTLIT
    } mode_e;

    typedef struct packed {
        loc_kind_e         kind;
        logic [WORD_W-1:0] sel;
        logic [WORD_W-1:0] lit;
        logic              used;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] sp;
    } opd_result_t;

    function automatic mode_e mode_of(input logic [CODE_W-1:0] c);
        mode_e m;
        if (c[CODE_W-1])            m = M_SHORTLIT;
        else if (c[4:3] == 2'b00)   m = M_REG;
        else if (c[4:3] == 2'b01)   m = M_IND;
        else if (c[4:3] == 2'b10)   m = M_IDX;
        else begin
            case (c[2:0])
                3'd0:    m = M_POP;
                3'd1:    m = M_PEEK;
                3'd2:    m = M_PUSH;
                3'd6:    m = M_ABS;
                3'd7:    m = M_NEXTLIT;
                default: m = M_SPR;
            endcase
        end
        return m;
    endfunction

    function automatic logic consumes_word(input mode_e m);
        return (m == M_IDX) || (m == M_ABS) || (m == M_NEXTLIT);
    endfunction
endpackage

// File: rtl/opd_classify.sv
module opd_classify
    import opd_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output mode_e             mode,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              used
);
    always_comb begin
        mode    = mode_of(code);
        reg_idx = code[IDX_W-1:0];
        used    = consumes_word(mode);
    end
endmodule

// File: rtl/opd_addr_gen.sv
module opd_addr_gen
    import opd_pkg::*;
(
    input  mode_e                       mode,
    input  logic [IDX_W-1:0]            reg_idx,
    input  logic [NUM_REGS*WORD_W-1:0]  gprs,
    input  logic [WORD_W-1:0]           sp,
    input  logic [WORD_W-1:0]           nword,
    output logic [WORD_W-1:0]           addr,
    output logic [WORD_W-1:0]           sp_out
);
    logic [WORD_W-1:0] reg_val;
    logic [WORD_W-1:0] sp_dec;

    always_comb begin
        reg_val = gprs[reg_idx*WORD_W +: WORD_W];
        sp_dec  = sp - WORD_W'(1);
        sp_out  = sp;
        case (mode)
            M_IND:   addr = reg_val;
            M_IDX:   addr = reg_val + nword;
            M_POP: begin
                addr   = sp;
                sp_out = sp + WORD_W'(1);
            end
            M_PEEK:  addr = sp;
            M_PUSH: begin
                addr   = sp_dec;
                sp_out = sp_dec;
            end
            M_ABS:   addr = nword;
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/operand_mode_decoder.sv
module operand_mode_decoder
    import opd_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [CODE_W-1:0]           opnd_code,
    input  logic [NUM_REGS*WORD_W-1:0]  gpr_values,
    input  logic [WORD_W-1:0]           sp_in,
    input  logic [WORD_W-1:0]           pc_in,
    input  logic [WORD_W-1:0]           next_word,
    output logic                        out_valid,
    output logic [1:0]                  loc_kind,
    output logic [WORD_W-1:0]           loc_sel,
    output logic [WORD_W-1:0]           lit_value,
    output logic                        word_used,
    output logic [WORD_W-1:0]           pc_next,
    output logic [WORD_W-1:0]           sp_next
);
    localparam logic [CODE_W-1:0] SPR_BASE = CODE_W'(6'h1B);

    mode_e             mode;
    logic [IDX_W-1:0]  reg_idx;
    logic              used;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] sp_calc;
    opd_result_t       nxt;
    opd_result_t       res_q;

    opd_classify u_cls (
        .code    (opnd_code),
        .mode    (mode),
        .reg_idx (reg_idx),
        .used    (used)
    );

    opd_addr_gen u_agen (
        .mode    (mode),
        .reg_idx (reg_idx),
        .gprs    (gpr_values),
        .sp      (sp_in),
        .nword   (next_word),
        .addr    (addr),
        .sp_out  (sp_calc)
    );

    always_comb begin
        nxt      = '0;
        nxt.used = used;
        nxt.pc   = pc_in + WORD_W'(used);
        nxt.sp   = sp_calc;
        case (mode)
            M_REG: begin
                nxt.kind = LOC_GPR;
                nxt.sel  = WORD_W'(reg_idx);
            end
            M_SPR: begin
                nxt.kind = LOC_SPEC;
                nxt.sel  = WORD_W'(opnd_code - SPR_BASE);
            end
            M_NEXTLIT: begin
                nxt.kind = LOC_LIT;
                nxt.lit  = next_word;
            end
            M_SHORTLIT: begin
                nxt.kind = LOC_LIT;
                nxt.lit  = WORD_W'(opnd_code[LIT_W-1:0]);
            end
            default: begin
                nxt.kind = LOC_MEM;
                nxt.sel  = addr;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) res_q <= nxt;
        end
    end

    assign loc_kind  = res_q.kind;
    assign loc_sel   = res_q.sel;
    assign lit_value = res_q.lit;
    assign word_used = res_q.used;
    assign pc_next   = res_q.pc;
    assign sp_next   = res_q.sp;

    // R12: a result follows every request one cycle later
    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R12: reset leaves no result pending
    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> !out_valid);
    // R11: indexed codes consume the following word and step the PC
    a_r11_indexed_uses_word: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opnd_code[5:3] == 3'b010) |=> (word_used && pc_next == $past(pc_in) + WORD_W'(1)));
    // R10: short literals consume no word
    a_r10_short_literal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opnd_code[5]) |=> (loc_kind == 2'd3 && !word_used && loc_sel == '0));
    // R4: a pop advances the stack pointer
    a_r4_pop_sp: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opnd_code == 6'h18) |=> (sp_next == $past(sp_in) + WORD_W'(1) && loc_sel == $past(sp_in)));
    // R6: a push addresses the new stack top
    a_r6_push_addr: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opnd_code == 6'h1A) |=> (loc_sel == sp_next && sp_next == $past(sp_in) - WORD_W'(1)));
endmodule

// File: tb/operand_mode_decoder_test.sv
module operand_mode_decoder_test;
    typedef struct {
        logic [5:0]  code;
        logic [1:0]  kind;
        logic [15:0] sel;
        logic [15:0] lit;
        logic        used;
        logic [15:0] pc;
        logic [15:0] sp;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [5:0]   opnd_code = '0;
    logic [127:0] gpr_values = '0;
    logic [15:0]  sp_in = '0;
    logic [15:0]  pc_in = '0;
    logic [15:0]  next_word = '0;
    logic         out_valid;
    logic [1:0]   loc_kind;
    logic [15:0]  loc_sel;
    logic [15:0]  lit_value;
    logic         word_used;
    logic [15:0]  pc_next;
    logic [15:0]  sp_next;

    int checks = 0;
    int fails  = 0;
    exp_t sb_q[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    operand_mode_decoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_code(opnd_code),
        .gpr_values(gpr_values), .sp_in(sp_in), .pc_in(pc_in), .next_word(next_word),
        .out_valid(out_valid), .loc_kind(loc_kind), .loc_sel(loc_sel),
        .lit_value(lit_value), .word_used(word_used), .pc_next(pc_next), .sp_next(sp_next)
    );

    function automatic string req_of(input logic [5:0] c);
        if (c >= 6'h20) return "R10";
        if (c <= 6'h07) return "R1";
        if (c <= 6'h0F) return "R2";
        if (c <= 6'h17) return "R3";
        case (c)
            6'h18: return "R4";
            6'h19: return "R5";
            6'h1A: return "R6";
            6'h1E: return "R8";
            6'h1F: return "R9";
            default: return "R7";
        endcase
    endfunction

    function automatic exp_t model(input logic [5:0] c, input logic [127:0] g,
                                   input logic [15:0] sp, input logic [15:0] pc,
                                   input logic [15:0] nw);
        exp_t e;
        logic [15:0] rv;
        rv = g[c[2:0]*16 +: 16];
        e.code = c; e.kind = 2'd1; e.sel = '0; e.lit = '0; e.used = 1'b0; e.sp = sp;
        if (c >= 6'h20) begin e.kind = 2'd3; e.lit = {11'd0, c[4:0]}; end
        else if (c <= 6'h07) begin e.kind = 2'd0; e.sel = {13'd0, c[2:0]}; end
        else if (c <= 6'h0F) e.sel = rv;
        else if (c <= 6'h17) begin e.sel = rv + nw; e.used = 1'b1; end
        else if (c == 6'h18) begin e.sel = sp; e.sp = sp + 16'd1; end
        else if (c == 6'h19) e.sel = sp;
        else if (c == 6'h1A) begin e.sel = sp - 16'd1; e.sp = sp - 16'd1; end
        else if (c == 6'h1B) begin e.kind = 2'd2; e.sel = 16'd0; end
        else if (c == 6'h1C) begin e.kind = 2'd2; e.sel = 16'd1; end
        else if (c == 6'h1D) begin e.kind = 2'd2; e.sel = 16'd2; end
        else if (c == 6'h1E) begin e.sel = nw; e.used = 1'b1; end
        else begin e.kind = 2'd3; e.lit = nw; e.used = 1'b1; end
        e.pc = pc + {15'd0, e.used};
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic send(input logic [5:0] c, input logic [127:0] g, input logic [15:0] sp,
                        input logic [15:0] pc, input logic [15:0] nw);
        @(negedge clk);
        opnd_code = c; gpr_values = g; sp_in = sp; pc_in = pc; next_word = nw;
        in_valid = 1'b1;
        sb_q.push_back(model(c, g, sp, pc, nw));
    endtask

    // monitor: compares each result against the oldest expected item
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R12", "unexpected out_valid", 16'd1, 16'd0);
            end else begin
                exp_t e;
                string r;
                e = sb_q.pop_front();
                r = req_of(e.code);
                check(loc_kind == e.kind, r, "kind", {14'd0, loc_kind}, {14'd0, e.kind});
                check(loc_sel == e.sel, r, "sel", loc_sel, e.sel);
                check(lit_value == e.lit, (e.kind == 2'd3) ? r : "R13", "lit", lit_value, e.lit);
                check(word_used == e.used, "R11", "used", {15'd0, word_used}, {15'd0, e.used});
                check(pc_next == e.pc, "R11", "pc", pc_next, e.pc);
                check(sp_next == e.sp, (e.code == 6'h18 || e.code == 6'h1A) ? r : "R5",
                      "sp", sp_next, e.sp);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R12", "watchdog expired", 16'd0, 16'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : driver
        logic [127:0] g;
        g = '0;
        for (int i = 0; i < 8; i++) g[i*16 +: 16] = 16'h1000 * (i + 1) + 16'h0011 * i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        check(out_valid == 1'b0, "R12", "out_valid after reset", {15'd0, out_valid}, 16'd0);
        check(loc_sel == '0 && sp_next == '0 && pc_next == '0, "R12", "outputs after reset",
              loc_sel, 16'd0);
        // all codes, ordinary values
        for (int c = 0; c < 64; c++)
            send(6'(c), g, 16'h8000 + 16'(c), 16'h0200 + 16'(c), 16'h0123 * 16'(c + 1));
        // R3 wrap: register 0xFFFF plus following word 2
        g[5*16 +: 16] = 16'hFFFF;
        send(6'h15, g, 16'h4000, 16'h0010, 16'h0002);
        // R6 push wrap from 0
        send(6'h1A, g, 16'h0000, 16'h0010, 16'h0000);
        // R4 pop wrap from 0xFFFF
        send(6'h18, g, 16'hFFFF, 16'h0010, 16'h0000);
        // R11 program counter wrap
        send(6'h1F, g, 16'h1234, 16'hFFFF, 16'hBEEF);
        send(6'h1E, g, 16'h1234, 16'hFFFF, 16'hCAFE);
        send(6'h3F, g, 16'h1234, 16'hFFFF, 16'h5555);
        // varied patterns
        for (int k = 0; k < 40; k++) begin
            logic [5:0] c;
            c = 6'((k * 37 + 11) % 64);
            for (int i = 0; i < 8; i++) g[i*16 +: 16] = 16'((k * 4099 + i * 257) ^ 16'hA5A5);
            send(c, g, 16'((k * 977) ^ 16'h00FF), 16'(k * 1231), 16'((k * 7919) ^ 16'h3C3C));
        end
        // R12: gap with no request, then valid must drop
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R12", "out_valid idle", {15'd0, out_valid}, 16'd0);
        check(sb_q.size() == 0, "R12", "results missing", 16'(sb_q.size()), 16'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule